// File: doc/BRIEF.md
# Sequencer Instruction RAM Loader

This block lets a host processor fill and inspect the instruction memory of a small embedded sequencer through a byte-wide register port. The memory stores 32-bit instruction words. The host picks one of four byte registers with a 2-bit select. A control register gates loading and drives the sequencer's reset line. Two address registers hold a 9-bit word address: a low byte and a single stored bit in the high register. A data window register carries the instruction bytes.

A word is loaded by writing four bytes in a row to the window, least significant byte first. The memory is written only on the fourth byte, and the word address then steps by one. This allows a whole program to be streamed by setting the address once and then writing bytes. Reads through the window return the stored bytes in the same order and step the address after the fourth byte. The sequencer fetches instructions through a separate read port with a one-cycle latency. The asynchronous active-low reset is released synchronously inside the block.

Top module: `seq_iram_loader`

## Requirements
- R1: After reset the control register, both address registers and the internal byte-lane pointer are zero, `seq_reset_o` is low, and reads of select 0, 1 and 2 return 0x00.
- R2: Select 0 is the control register. Bit 0 enables loading and bit 1 drives `seq_reset_o` from the cycle after the write. Bits 7:2 are not stored and read back as zero.
- R3: Select 1 holds address bits 7:0 and select 2 holds address bit 8 in its bit 0. The other bits of select 2 are not stored and read back as zero.
- R4: Window writes (select 3) with loading enabled fill byte lanes 0, 1, 2, 3 in that order, each lane holding bits 8*lane+7:8*lane. The memory word is written only by the lane-3 byte, and the first three bytes leave the stored word unchanged.
- R5: The word address increments by one after the lane-3 byte is written, and it wraps from 511 to 0. It does not change on the first three bytes.
- R6: A window write while the load enable is 0 changes neither the memory, the address nor the lane pointer.
- R7: Writing select 1 or select 2 returns the lane pointer to lane 0, so a partly assembled word is dropped.
- R8: A window read returns byte lane `lane` of the word at the current address, lane 0 first. The address advances after the lane-3 byte is read. `host_rdata` takes the value of any read on the clock edge where `host_rd` is sampled and holds it until the next read. When `host_wr` and `host_rd` are both high in one cycle, the lane pointer moves only as the write dictates.
- R9: `fetch_data` presents the word stored at `fetch_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 2 | Register select: 0 control, 1 address low, 2 address high, 3 data window |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data byte, registered |
| seq_reset_o | output | 1 | Reset request to the sequencer core (control bit 1) |
| fetch_addr | input | 9 | Sequencer instruction fetch word address |
| fetch_data | output | 32 | Fetched instruction word, one cycle latency |

## Verification
A lane pointer that is off by one shows up at the first complete word. The stored word appears byte-rotated on the fetch port one cycle after the address is applied. The low address register also advances one write early or late, which a readback two cycles later exposes. A missed lane reset on an address write, or a window write that slips through while loading is off, leaves the next word assembled at the wrong position. Partial words are therefore checked against a word known to be stored there. The address register is read back after each group of bytes, so that an early or missing step is caught within the same word.

// File: rtl/seq_iram_pkg.sv
package seq_iram_pkg;

  // Host register selects
  localparam logic [1:0] SEL_CTRL    = 2'd0;
  localparam logic [1:0] SEL_ADDR_LO = 2'd1;
  localparam logic [1:0] SEL_ADDR_HI = 2'd2;
  localparam logic [1:0] SEL_WINDOW  = 2'd3;

  // Control register bit positions
  localparam int CTRL_LOAD_BIT   = 0;
  localparam int CTRL_SEQRST_BIT = 1;
  localparam int CTRL_W          = 2;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/seq_iram_rst_sync.sv
module seq_iram_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/seq_iram_ptr.sv
// Word address and byte-lane pointer shared by window reads and writes.
module seq_iram_ptr #(
  parameter int ADDR_W = 9,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_lo,
  input  logic              set_hi,
  input  logic [7:0]        set_data,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_o,
  output logic [$clog2(BYTES)-1:0] lane_o,
  output logic              last_lane_o
);

  localparam int LANE_W = $clog2(BYTES);
  localparam int HI_W   = ADDR_W - 8;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LANE_W-1:0] lane_q, lane_d;

  always_comb begin
    addr_d = addr_q;
    lane_d = lane_q;
    if (set_lo) begin
      addr_d[7:0] = set_data;
      lane_d      = '0;
    end else if (set_hi) begin
      addr_d[ADDR_W-1:8] = set_data[HI_W-1:0];
      lane_d             = '0;
    end else if (step) begin
      if (lane_q == LAST_LANE) begin
        lane_d = '0;
        addr_d = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
      end else begin
        lane_d = lane_q + {{(LANE_W-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lane_q <= '0;
    end else begin
      addr_q <= addr_d;
      lane_q <= lane_d;
    end
  end

  assign addr_o      = addr_q;
  assign lane_o      = lane_q;
  assign last_lane_o = (lane_q == LAST_LANE);

endmodule

// File: rtl/seq_iram_asm.sv
// Holds the lower byte lanes of a word until the top lane arrives.
module seq_iram_asm #(
  parameter int BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture,
  input  logic [$clog2(BYTES)-1:0]   lane,
  input  logic [7:0]                 byte_i,
  output logic [BYTES*8-1:0]         word_o
);

  localparam int LANE_W = $clog2(BYTES);

  logic [7:0] hold_q [BYTES-1];
  logic [7:0] hold_d [BYTES-1];

  for (genvar g = 0; g < BYTES - 1; g++) begin : g_lane
    always_comb begin
      hold_d[g] = hold_q[g];
      if (capture && (lane == LANE_W'(g))) begin
        hold_d[g] = byte_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[g] <= '0;
      end else begin
        hold_q[g] <= hold_d[g];
      end
    end

    assign word_o[g*8 +: 8] = hold_q[g];
  end

  assign word_o[(BYTES-1)*8 +: 8] = byte_i;

endmodule

// File: rtl/seq_iram_store.sv
// Instruction word storage: one write port, one combinational host read,
// one registered fetch read.
module seq_iram_store #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [DATA_W-1:0] host_rword,
  input  logic [ADDR_W-1:0] fetch_raddr,
  output logic [DATA_W-1:0] fetch_rword
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] fetch_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    fetch_q <= mem[fetch_raddr];
  end

  assign host_rword  = mem[host_raddr];
  assign fetch_rword = fetch_q;

endmodule

// File: rtl/seq_iram_loader.sv
module seq_iram_loader
  import seq_iram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BYTES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          host_sel,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  output logic                seq_reset_o,
  input  logic [ADDR_W-1:0]   fetch_addr,
  output logic [BYTES*8-1:0]  fetch_data
);

  localparam int LANE_W = $clog2(BYTES);
  localparam int WORD_W = BYTES * 8;
  localparam int HI_W   = ADDR_W - 8;

  logic                rst_n_s;
  logic [CTRL_W-1:0]   ctrl_q, ctrl_d;
  logic [ADDR_W-1:0]   cur_addr;
  logic [LANE_W-1:0]   cur_lane;
  logic                last_lane;
  logic                sel_win;
  logic                win_wr;
  logic                win_step;
  logic                mem_we;
  logic [WORD_W-1:0]   asm_word;
  logic [WORD_W-1:0]   host_word;
  logic [WORD_W-1:0]   lane_shifted;
  logic [LANE_W+2:0]   lane_bit;
  logic [7:0]          rd_byte;
  logic [7:0]          rdata_q, rdata_d;

  seq_iram_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  // Strobe decode: a cycle with both strobes on the window acts as a write.
  assign sel_win  = (host_sel == SEL_WINDOW);
  assign win_wr   = host_wr && sel_win && ctrl_q[CTRL_LOAD_BIT];
  assign win_step = win_wr || (host_rd && sel_win && !host_wr);
  assign mem_we   = win_wr && last_lane;

  // Control register
  always_comb begin
    ctrl_d = ctrl_q;
    if (host_wr && (host_sel == SEL_CTRL)) begin
      ctrl_d = host_wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign seq_reset_o = ctrl_q[CTRL_SEQRST_BIT];

  seq_iram_ptr #(
    .ADDR_W (ADDR_W),
    .BYTES  (BYTES)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .set_lo      (host_wr && (host_sel == SEL_ADDR_LO)),
    .set_hi      (host_wr && (host_sel == SEL_ADDR_HI)),
    .set_data    (host_wdata),
    .step        (win_step),
    .addr_o      (cur_addr),
    .lane_o      (cur_lane),
    .last_lane_o (last_lane)
  );

  seq_iram_asm #(
    .BYTES (BYTES)
  ) u_asm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .capture (win_wr),
    .lane    (cur_lane),
    .byte_i  (host_wdata),
    .word_o  (asm_word)
  );

  seq_iram_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (WORD_W)
  ) u_store (
    .clk         (clk),
    .we          (mem_we),
    .waddr       (cur_addr),
    .wdata       (asm_word),
    .host_raddr  (cur_addr),
    .host_rword  (host_word),
    .fetch_raddr (fetch_addr),
    .fetch_rword (fetch_data)
  );

  // Read path
  assign lane_bit     = {cur_lane, 3'b000};
  assign lane_shifted = host_word >> lane_bit;

  always_comb begin
    rd_byte = '0;
    case (host_sel)
      SEL_CTRL:    rd_byte = {{(8-CTRL_W){1'b0}}, ctrl_q};
      SEL_ADDR_LO: rd_byte = cur_addr[7:0];
      SEL_ADDR_HI: rd_byte = {{(8-HI_W){1'b0}}, cur_addr[ADDR_W-1:8]};
      default:     rd_byte = lane_shifted[7:0];
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (host_rd) begin
      rdata_d = rd_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign host_rdata = rdata_q;

endmodule

// File: rtl/seq_iram_loader_chk.sv
module seq_iram_loader_chk #(
  parameter int ADDR_W = 9,
  parameter int LANE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        host_sel,
  input logic              host_wr,
  input logic [7:0]        host_wdata,
  input logic              load_en,
  input logic              seq_reset_o,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [LANE_W-1:0] cur_lane,
  input logic              mem_we
);

  localparam logic [LANE_W-1:0] TOP_LANE = '1;

  logic [ADDR_W-1:0] addr_inc;
  assign addr_inc = cur_addr + {{(ADDR_W-1){1'b0}}, 1'b1};

  // R5: address steps once the top lane is written
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 2'd3 && load_en && cur_lane == TOP_LANE)
      |=> (cur_addr == $past(addr_inc)));

  // R6: locked window writes touch neither address nor lane
  a_r6_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 2'd3 && !load_en)
      |=> ($stable(cur_addr) && $stable(cur_lane)));

  // R7: address register writes clear the lane pointer
  a_r7_lane_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_sel == 2'd1 || host_sel == 2'd2)) |=> (cur_lane == '0));

  // R4: memory written only by an enabled top-lane window write
  a_r4_store_on_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (host_wr && host_sel == 2'd3 && load_en && cur_lane == TOP_LANE));

  // R2: sequencer reset follows control bit 1
  a_r2_seqrst_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 2'd0) |=> (seq_reset_o == $past(host_wdata[1])));

endmodule

bind seq_iram_loader seq_iram_loader_chk #(
  .ADDR_W (ADDR_W),
  .LANE_W (LANE_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .host_sel    (host_sel),
  .host_wr     (host_wr),
  .host_wdata  (host_wdata),
  .load_en     (ctrl_q[0]),
  .seq_reset_o (seq_reset_o),
  .cur_addr    (cur_addr),
  .cur_lane    (cur_lane),
  .mem_we      (mem_we)
);

// File: tb/seq_iram_loader_tb_top.sv
module seq_iram_loader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 9;
  localparam int NVEC       = 25;

  // vector: {kind[1:0], sel[1:0], data[7:0], expect[7:0]}; kind 0 write, 1 read-compare
  localparam logic [19:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 8'h01, 8'h00},
    {2'd0, 2'd1, 8'h10, 8'h00},
    {2'd0, 2'd2, 8'h01, 8'h00},
    {2'd0, 2'd3, 8'h11, 8'h00},
    {2'd0, 2'd3, 8'h22, 8'h00},
    {2'd0, 2'd3, 8'h33, 8'h00},
    {2'd0, 2'd3, 8'h44, 8'h00},
    {2'd1, 2'd1, 8'h00, 8'h11},
    {2'd1, 2'd2, 8'h00, 8'h01},
    {2'd0, 2'd3, 8'hAA, 8'h00},
    {2'd0, 2'd3, 8'hBB, 8'h00},
    {2'd0, 2'd3, 8'hCC, 8'h00},
    {2'd0, 2'd3, 8'hDD, 8'h00},
    {2'd0, 2'd1, 8'h10, 8'h00},
    {2'd1, 2'd3, 8'h00, 8'h11},
    {2'd1, 2'd3, 8'h00, 8'h22},
    {2'd1, 2'd3, 8'h00, 8'h33},
    {2'd1, 2'd3, 8'h00, 8'h44},
    {2'd1, 2'd1, 8'h00, 8'h11},
    {2'd1, 2'd3, 8'h00, 8'hAA},
    {2'd1, 2'd3, 8'h00, 8'hBB},
    {2'd1, 2'd3, 8'h00, 8'hCC},
    {2'd1, 2'd3, 8'h00, 8'hDD},
    {2'd1, 2'd1, 8'h00, 8'h12},
    {2'd1, 2'd0, 8'h00, 8'h01}
  };

  logic              clk;
  logic              rst_n;
  logic [1:0]        host_sel;
  logic              host_wr;
  logic              host_rd;
  logic [7:0]        host_wdata;
  logic [7:0]        host_rdata;
  logic              seq_reset_o;
  logic [ADDR_W-1:0] fetch_addr;
  logic [31:0]       fetch_data;

  int n_checks;
  int n_fail;
  bit finished;

  seq_iram_loader dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_sel    (host_sel),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .seq_reset_o (seq_reset_o),
    .fetch_addr  (fetch_addr),
    .fetch_data  (fetch_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_sel   = sel;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel;
    host_rd  = 1'b1;
    @(negedge clk);
    host_rd  = 1'b0;
    d        = host_rdata;
  endtask

  task automatic rd_check(input string req, input logic [1:0] sel, input logic [7:0] exp);
    logic [7:0] d;
    bus_rd(sel, d);
    check(req, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic fetch_check(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    fetch_addr = a;
    @(negedge clk);
    check(req, fetch_data, exp);
  endtask

  task automatic wr_word(input logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      bus_wr(2'd3, w[b*8 +: 8]);
    end
  endtask

  function automatic string sel_req(input logic [1:0] sel);
    case (sel)
      2'd0:    return "R2 table ctrl readback";
      2'd3:    return "R8 table window read";
      default: return "R3/R5 table address readback";
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks   = 0;
    n_fail     = 0;
    finished   = 1'b0;
    rst_n      = 1'b0;
    host_sel   = 2'd0;
    host_wr    = 1'b0;
    host_rd    = 1'b0;
    host_wdata = 8'h00;
    fetch_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 seq_reset low", {31'd0, seq_reset_o}, 32'd0);
    rd_check("R1 ctrl zero", 2'd0, 8'h00);
    rd_check("R1 addr lo zero", 2'd1, 8'h00);
    rd_check("R1 addr hi zero", 2'd2, 8'h00);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][19:18] == 2'd0) begin
        bus_wr(VEC[i][17:16], VEC[i][15:8]);
      end else begin
        rd_check(sel_req(VEC[i][17:16]), VEC[i][17:16], VEC[i][7:0]);
      end
    end
    fetch_check("R9 fetch word 0x110", 9'h110, 32'h44332211);
    fetch_check("R9 fetch word 0x111", 9'h111, 32'hDDCCBBAA);

    // R4: partial word leaves memory alone, top lane stores
    bus_wr(2'd1, 8'h40);
    bus_wr(2'd2, 8'h00);
    wr_word(32'h01020304);
    fetch_check("R4 full word at 0x040", 9'h040, 32'h01020304);
    bus_wr(2'd1, 8'h40);
    bus_wr(2'd3, 8'h9A);
    bus_wr(2'd3, 8'h9B);
    bus_wr(2'd3, 8'h9C);
    fetch_check("R4 three bytes leave word unchanged", 9'h040, 32'h01020304);
    rd_check("R5 no step before top lane", 2'd1, 8'h40);
    bus_wr(2'd3, 8'h9D);
    fetch_check("R4 top lane stores word", 9'h040, 32'h9D9C9B9A);
    rd_check("R5 step after top lane", 2'd1, 8'h41);

    // R7: address write drops partial word
    bus_wr(2'd1, 8'h30);
    bus_wr(2'd3, 8'h01);
    bus_wr(2'd3, 8'h02);
    bus_wr(2'd1, 8'h30);
    wr_word(32'h88776655);
    fetch_check("R7 lane cleared by address write", 9'h030, 32'h88776655);
    rd_check("R7 address after realigned word", 2'd1, 8'h31);

    // R6: locked window writes ignored
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd1, 8'h40);
    wr_word(32'hEEEEEEEE);
    rd_check("R6 address unchanged while locked", 2'd1, 8'h40);
    fetch_check("R6 memory unchanged while locked", 9'h040, 32'h9D9C9B9A);
    bus_wr(2'd0, 8'h01);
    wr_word(32'h14131211);
    fetch_check("R6 lane untouched while locked", 9'h040, 32'h14131211);
    rd_check("R6 address after unlocked word", 2'd1, 8'h41);

    // R5: wrap at top of memory
    bus_wr(2'd1, 8'hFF);
    bus_wr(2'd2, 8'h01);
    wr_word(32'hA3A2A1A0);
    rd_check("R5 wrap low byte", 2'd1, 8'h00);
    rd_check("R5 wrap high bit", 2'd2, 8'h00);
    fetch_check("R5 word at 0x1FF", 9'h1FF, 32'hA3A2A1A0);

    // R3: only bit 0 of high address stored
    bus_wr(2'd2, 8'hFE);
    rd_check("R3 hi unused bits dropped", 2'd2, 8'h00);
    bus_wr(2'd2, 8'hFF);
    rd_check("R3 hi bit 0 stored", 2'd2, 8'h01);

    // R8: read back across wrap, then R2 control
    bus_wr(2'd1, 8'hFF);
    rd_check("R8 lane 0 read at 0x1FF", 2'd3, 8'hA0);
    rd_check("R8 lane 1 read at 0x1FF", 2'd3, 8'hA1);
    rd_check("R8 lane 2 read at 0x1FF", 2'd3, 8'hA2);
    rd_check("R8 lane 3 read at 0x1FF", 2'd3, 8'hA3);
    rd_check("R8 address wrapped after read", 2'd2, 8'h00);

    bus_wr(2'd0, 8'h03);
    check("R2 seq_reset set", {31'd0, seq_reset_o}, 32'd1);
    rd_check("R2 ctrl readback", 2'd0, 8'h03);
    bus_wr(2'd0, 8'hFD);
    check("R2 seq_reset cleared", {31'd0, seq_reset_o}, 32'd0);
    rd_check("R2 upper ctrl bits dropped", 2'd0, 8'h01);

    finish_run();
  end

endmodule